// File: doc/BRIEF.md
# Byte-Wide Serial Slave with Flag-Sequenced Handshake

This block is the receive-and-transmit end of a four-wire synchronous serial link, with the block acting as the slave. An external master supplies the serial clock, the active-low select and the master-to-slave data line. The block returns one byte on its output line for every byte it receives. The clock polarity and the clock phase are set by software, and both must match the master. A local processor talks to the block through three byte registers: a control register, a status register and a data register. The processor loads the byte to send by writing the data register. It collects the received byte by reading the same address.

Each received byte is copied into a separate read buffer at the moment the byte completes, so the shift register is free for the next byte at once. Completion raises a flag and, if enabled, an interrupt request. The flag clears only after a fixed two-step access: a status read while the flag is set, then a data-register access. Until that status read, writes to the data register are ignored. The block also reports two error conditions. An overrun is a byte that completes before the previous one was acknowledged. A write collision is a data write made while a transfer is under way in phase-0 mode.

The serial inputs pass through two-flop synchronizers, and the clock edges are found on the synchronized clock. The system clock must therefore run at least four times faster than the serial clock.

Top module: `spi_slave_port`

## Requirements
- R1: After reset the control, status and data registers all read 0, and `irq` and `miso_oe` are low.
- R2: Control register (address 0) bits: bit0 enable, bit1 host-mode (always reads 0, writes ignored), bit2 idle-high clock, bit3 late phase, bit4 interrupt enable. The block shifts and drives `miso` (`miso_oe`=1) only while enabled and `ss_n` is low.
- R3: In mode 0 (bit2=0, bit3=0) a byte is exchanged full duplex, most significant bit first. The byte written to the data register (address 2) appears on `miso`, and the byte on `mosi` is received.
- R4: Transfers are correct in all four combinations of clock polarity and phase.
- R5: When the last bit of a byte is sampled, status bit7 (done) sets and the received byte is copied to the read buffer. Data-register reads return that buffer.
- R6: `irq` is high exactly when done=1, interrupt enable=1 and `irq_mask`=0.
- R7: Done clears only after a status read (address 1) made while a flag is set, followed by a data-register read or write. A data access without the preceding status read leaves done set.
- R8: While done is set and the status has not yet been read, data-register writes are ignored. A write that follows the status read is accepted and also clears the flags.
- R9: If a byte completes while done is still set, status bit5 (overrun) sets and the read buffer keeps the earlier byte.
- R10: In phase-0 mode (bit3=0), a data write made while the block is enabled and `ss_n` is low sets status bit6 (collision) and is discarded.
- R11: If `ss_n` rises part-way through a byte, the partial byte is dropped and the next full byte is received correctly.
- R12: The overrun and collision flags clear by the same status-read-then-data-access sequence as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | AW | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for the addressed register (combinational) |
| irq_mask | input | 1 | Global interrupt mask, active high |
| irq | output | 1 | Interrupt request |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
Most internal faults in this block become visible within one byte time. A wrong bit count or a wrong edge choice garbles the byte that the master reads back on `miso`, or the byte that software reads from the data register, by the end of that same transfer. Errors in the handshake state show up only at the next register access. A missed status-read mark leaves done stuck at the following data access. A wrongly accepted write shows up as the wrong byte on the next transfer. The tests therefore pair each handshake step with a status read, and with a transfer whose output is compared with what the master should see.

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          irq_mask,
  output logic          irq,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CW = $clog2(W);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);

  logic [1:0] sck_q, ss_q, mosi_q;
  logic sck_d;
  logic en, cpol, cpha, irq_en;
  logic done, ovr, wcol, seen;
  logic [W-1:0] sr, rxbuf;
  logic [CW-1:0] cnt;
  logic samp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; ss_q <= '1; mosi_q <= '0; sck_d <= 1'b0;
    end else begin
      sck_q  <= {sck_q[0], sck};
      ss_q   <= {ss_q[0], ss_n};
      mosi_q <= {mosi_q[0], mosi};
      sck_d  <= sck_q[1];
    end

  wire sck_s  = sck_q[1];
  wire ss_s   = ss_q[1];
  wire mosi_s = mosi_q[1];
  wire active = en & ~ss_s;
  wire rise   = sck_s & ~sck_d;
  wire fall   = ~sck_s & sck_d;
  wire lead   = cpol ? fall : rise;
  wire trail  = cpol ? rise : fall;
  wire smp_e  = active & (cpha ? trail : lead);
  wire sft_e  = active & (cpha ? lead : trail) & (cnt != '0);
  wire last   = smp_e & (cnt == CW'(W-1));
  wire [W-1:0] rx_word = {sr[W-2:0], mosi_s};

  wire ctl_wr  = reg_wr & (reg_addr == A_CTRL);
  wire st_rd   = reg_rd & (reg_addr == A_STAT);
  wire dat_rd  = reg_rd & (reg_addr == A_DATA);
  wire dat_wr  = reg_wr & (reg_addr == A_DATA);
  wire clr     = (dat_rd | dat_wr) & seen;
  wire blocked = dat_wr & done & ~seen;
  wire coll    = dat_wr & ~blocked & ~cpha & active;
  wire load    = dat_wr & ~blocked & ~coll;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; irq_en <= 1'b0;
    end else if (ctl_wr) begin
      en <= reg_wdata[0]; cpol <= reg_wdata[2];
      cpha <= reg_wdata[3]; irq_en <= reg_wdata[4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; samp <= 1'b0; cnt <= '0;
    end else begin
      if (load) sr <= reg_wdata;
      else if (sft_e) sr <= {sr[W-2:0], samp};
      if (smp_e) samp <= mosi_s;
      if (!active) cnt <= '0;
      else if (smp_e) cnt <= last ? '0 : cnt + 1'b1;
    end

  logic done_nx, ovr_nx, wcol_nx, buf_ld;
  always_comb begin
    done_nx = done & ~clr;
    ovr_nx  = ovr & ~clr;
    wcol_nx = (wcol & ~clr) | coll;
    buf_ld  = 1'b0;
    if (last) begin
      if (done_nx) ovr_nx = 1'b1;
      else begin
        done_nx = 1'b1;
        buf_ld  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b0; ovr <= 1'b0; wcol <= 1'b0; seen <= 1'b0; rxbuf <= '0;
    end else begin
      done <= done_nx; ovr <= ovr_nx; wcol <= wcol_nx;
      if (buf_ld) rxbuf <= rx_word;
      if (clr) seen <= 1'b0;
      else if (st_rd & (done | ovr | wcol)) seen <= 1'b1;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0] = en; reg_rdata[2] = cpol;
        reg_rdata[3] = cpha; reg_rdata[4] = irq_en;
      end
      A_STAT: begin
        reg_rdata[W-1] = done; reg_rdata[W-2] = wcol; reg_rdata[W-3] = ovr;
      end
      A_DATA: reg_rdata = rxbuf;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = done & irq_en & ~irq_mask;
  assign miso    = active & sr[W-1];
  assign miso_oe = active;

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dat_rd && !dat_wr) |=> done);
  a_r7_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(seen && (dat_rd || dat_wr)));
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && done && !seen && !sft_e) |=> $stable(sr));
  a_r9_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (last && done && !clr) |=> ($stable(rxbuf) && ovr));
  a_r11_count_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (cnt == '0));
endmodule

// File: tb/sim_spi_slave_port.sv
module sim_spi_slave_port;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_mask = 0, irq, sck = 0, ss_n = 1, mosi = 0, miso, miso_oe;
  logic cpol_b = 0, cpha_b = 0;
  int errs = 0, nchk = 0;

  spi_slave_port u0 (.clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_mask(irq_mask), .irq(irq), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol_b = p; cpha_b = h;
    @(negedge clk); sck = p;
    wr(0, {3'b0, 1'b1, h, p, 1'b0, 1'b1});
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] got);
    got = 0;
    @(negedge clk); ss_n = 0; repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (!cpha_b) begin
        mosi = tx[7-i]; repeat (H) @(negedge clk);
        got = {got[6:0], miso}; sck = ~cpol_b; repeat (H) @(negedge clk);
        sck = cpol_b;
      end else begin
        sck = ~cpol_b; mosi = tx[7-i]; repeat (H) @(negedge clk);
        got = {got[6:0], miso}; sck = cpol_b; repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk); ss_n = 1; repeat (4) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    rd(1, d); rd(2, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 status", d, 0);
    rd(2, d); chk("R1 data", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 miso_oe", miso_oe, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(0, 8'h1F); rd(0, d); chk("R2 host bit reads 0", d, 8'h1D);
    chk("R2 no drive with ss high", miso_oe, 0);
    @(negedge clk); ss_n = 0; repeat (4) @(negedge clk);
    chk("R2 drive when selected", miso_oe, 1);
    wr(0, 8'h00); repeat (2) @(negedge clk);
    chk("R2 no drive when disabled", miso_oe, 0);
    ss_n = 1; repeat (4) @(negedge clk);
  endtask

  task automatic t_mode0();
    logic [7:0] d, got;
    set_mode(0, 0);
    wr(2, 8'hA5);
    xfer(8'h3C, 8, got);
    chk("R3 master receives", got, 8'hA5);
    rd(1, d); chk("R5 done set", d, 8'h80);
    chk("R6 irq high", irq, 1);
    @(negedge clk); irq_mask = 1; @(negedge clk);
    chk("R6 irq masked", irq, 0);
    irq_mask = 0;
    clear_flags();
    rd(1, d); chk("R7 cleared", d, 0);
    chk("R6 irq low after clear", irq, 0);
    wr(2, 8'h5A);
    xfer(8'hC3, 8, got);
    rd(2, d); chk("R3 slave receives", d, 8'hC3);
    rd(1, d); chk("R7 data read alone keeps done", d, 8'h80);
    rd(1, d); rd(2, d); chk("R5 buffer read", d, 8'hC3);
    rd(1, d); chk("R7 cleared by sequence", d, 0);
  endtask

  task automatic t_modes();
    logic [7:0] d, got;
    for (int m = 1; m < 4; m++) begin
      set_mode(m[0], m[1]);
      wr(2, 8'h96 ^ 8'(m));
      xfer(8'h4D + 8'(m), 8, got);
      chk("R4 master receives", got, 8'h96 ^ 8'(m));
      rd(1, d); rd(2, d); chk("R4 slave receives", d, 8'h4D + 8'(m));
    end
  endtask

  task automatic t_block();
    logic [7:0] d, got;
    set_mode(0, 0);
    wr(2, 8'h21); xfer(8'h3C, 8, got);
    wr(2, 8'h11);
    rd(1, d); wr(2, 8'h77);
    rd(1, d); chk("R8 write after status clears", d, 0);
    xfer(8'h00, 8, got);
    chk("R8 accepted write sent", got, 8'h77);
    wr(2, 8'h11);
    rd(1, d); rd(2, d);
    xfer(8'h00, 8, got);
    chk("R8 blocked write not sent", int'(got != 8'h11), 1);
    clear_flags();
  endtask

  task automatic t_ovr();
    logic [7:0] d, got;
    set_mode(0, 0);
    xfer(8'h12, 8, got);
    xfer(8'h34, 8, got);
    rd(1, d); chk("R9 overrun flag", d, 8'hA0);
    rd(2, d); chk("R9 buffer kept", d, 8'h12);
    rd(1, d); chk("R12 overrun cleared", d, 0);
  endtask

  task automatic t_wcol();
    logic [7:0] d, got;
    set_mode(0, 0);
    wr(2, 8'h99);
    @(negedge clk); ss_n = 0; repeat (4) @(negedge clk);
    wr(2, 8'h55);
    xfer(8'h0F, 8, got);
    chk("R10 write discarded", got, 8'h99);
    rd(1, d); chk("R10 collision flag", d, 8'hC0);
    rd(2, d); rd(1, d); chk("R12 collision cleared", d, 0);
  endtask

  task automatic t_abort();
    logic [7:0] d, got;
    set_mode(0, 0);
    wr(2, 8'hF0);
    xfer(8'hFF, 3, got);
    rd(1, d); chk("R11 partial byte dropped", d, 0);
    xfer(8'h5A, 8, got);
    rd(1, d); rd(2, d); chk("R11 next byte received", d, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    t_reset(); t_ctrl(); t_mode0(); t_modes(); t_block(); t_ovr(); t_wcol(); t_abort();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule